// File: doc/BRIEF.md
# Step-Commanded Two-Wire Bus Master

This block drives a two-wire serial bus (SCL clock, SDA data, both open-drain) as a master, one bus step at a time. A host issues a single command: begin a transfer with a START (a repeated START when it already holds the bus), shift out the byte held in the data register, shift in a byte while answering ACK or NACK, or end the transfer with a STOP. The engine performs that one step, raises a done flag and loads a 5-bit outcome code. It then holds SCL low, so the bus waits until the host issues the next command.

The bus clock comes from a prescaler (divide by 1, 4, 16 or 64) followed by a programmable divider, and each bit is split into four equal quarters. Both lines are driven through active-high pull-down enables and read back through input pins. Read-back is used in two ways. A slave that holds SCL low stretches the clock. A master that releases SDA but sees it low has lost arbitration, and it reports this.

Top module: `twi_step_master`

## Requirements
- R1: After reset both pull-down enables are off, `done` is 0, `wr_coll` is 0, `data_out` is 0x00 and the status code is the idle code 0x1F (status byte 0xF8 with prescaler select 00).
- R2: A START command releases SDA, then releases SCL, pulls SDA low while SCL is high, then pulls SCL low. The status is 0x08 when the bus was not held and 0x10 (repeated START) when a previous START has not been followed by a STOP or a lost arbitration.
- R3: A send command clocks 9 SCL pulses. The 8 data bits go out MSB first, and SDA changes only while SCL is low. SDA is released in the 9th clock, and the level read there is the receiver's answer (low means ACK).
- R4: The first send after a START is an address byte, and its bit 0 is the R/W bit (1 = read). It reports 0x18 on ACK or 0x20 on NACK when bit 0 is 0, and 0x40 or 0x48 when bit 0 is 1. Later sends report 0x28 on ACK and 0x30 on NACK.
- R5: A receive command releases SDA for 8 clocks and samples the byte MSB first into the data register. In the 9th clock it pulls SDA low when the command's ACK bit is 1 (status 0x50) and releases it otherwise (status 0x58).
- R6: A STOP command pulls SDA low while SCL is low, releases SCL, then releases SDA while SCL is high. It ends with both lines released, `done` set and status 0x1F.
- R7: `done` stays set until the next command is accepted. While `done` is set and the bus is held, SCL stays pulled low. A command is accepted only when no step is in progress, and a command that arrives during a step has no effect.
- R8: A data-register write is taken only while `done` is 1, and a taken write clears `wr_coll`. A write while `done` is 0 leaves the data register unchanged and sets `wr_coll`.
- R9: If SDA reads low in a bit that the master sends as released, the step ends at once with both lines released, `done` set and status 0x38. The bus is then no longer held, so the next START reports 0x08.
- R10: Each quarter bit lasts P*(D+1) clock cycles, where D is `rate_div` and P is 1, 4, 16 or 64 for `pre_sel` 00, 01, 10 or 11. The SCL period is therefore 4*P*(D+1) cycles.
- R11: Where SCL has been released and must be high before the step goes on, the engine waits for as long as SCL reads low.
- R12: The status byte carries the outcome code in bits 7:3, 0 in bit 2, and `pre_sel` in bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 START, 1 send byte, 2 receive byte, 3 STOP |
| cmd_ack | input | 1 | For receive: 1 answers ACK, 0 answers NACK |
| dat_wr | input | 1 | Data-register write strobe |
| dat_in | input | DW | Byte to write into the data register |
| pre_sel | input | 2 | Prescaler select |
| rate_div | input | DIV_W | Quarter-bit divider value |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| done | output | 1 | Step finished, waiting for the host |
| wr_coll | output | 1 | Last data write was rejected |
| status | output | 8 | Outcome code, 0, prescaler select |
| data_out | output | DW | Data register (byte to send or byte received) |

## Verification
The embedded assertions cover the properties that must hold on every cycle. SDA never moves while SCL is high inside a byte transfer, and SCL stays low while a finished step waits with the bus held. The done flag is cleared only by an accepted command, and a lost arbitration leaves both lines free. A rejected data write always sets the collision flag and never alters the register. The divider restarts from zero whenever it is idle. The directed scenarios cover what needs a bus partner: START, STOP and repeated START edges seen on the wire, address and data bytes answered with ACK or NACK, received bytes, a slave stretching the clock, a competing master forcing arbitration loss, and the measured SCL period at a non-default rate. Only these scenarios can confirm the exact outcome codes.

// File: rtl/twi_pkg.sv
package twi_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_SEND  = 2'd1,
    OP_RECV  = 2'd2,
    OP_STOP  = 2'd3
  } twi_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_XFER  = 2'd2,
    ST_STOP  = 2'd3
  } twi_st_e;

  // outcome codes, shown in status[7:3]
  localparam logic [4:0] C_START   = 5'h01;
  localparam logic [4:0] C_RSTART  = 5'h02;
  localparam logic [4:0] C_AW_ACK  = 5'h03;
  localparam logic [4:0] C_AW_NACK = 5'h04;
  localparam logic [4:0] C_TX_ACK  = 5'h05;
  localparam logic [4:0] C_TX_NACK = 5'h06;
  localparam logic [4:0] C_ARB     = 5'h07;
  localparam logic [4:0] C_AR_ACK  = 5'h08;
  localparam logic [4:0] C_AR_NACK = 5'h09;
  localparam logic [4:0] C_RX_ACK  = 5'h0A;
  localparam logic [4:0] C_RX_NACK = 5'h0B;
  localparam logic [4:0] C_IDLE    = 5'h1F;

endpackage

// File: rtl/twi_rate_gen.sv
module twi_rate_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [1:0]       pre_sel,
  input  logic [DIV_W-1:0] rate_div,
  output logic             tick
);

  localparam int PRE_W = 6;

  logic [PRE_W-1:0] pre_q, pre_d, pre_lim;
  logic [DIV_W-1:0] div_q, div_d;
  logic             pre_hit, div_hit;

  always_comb begin
    unique case (pre_sel)
      2'd0:    pre_lim = PRE_W'(0);
      2'd1:    pre_lim = PRE_W'(3);
      2'd2:    pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(63);
    endcase
  end

  assign pre_hit = (pre_q >= pre_lim);
  assign div_hit = (div_q >= rate_div);
  assign tick    = run && pre_hit && div_hit;

  always_comb begin
    pre_d = pre_q;
    div_d = div_q;
    if (!run) begin
      pre_d = '0;
      div_d = '0;
    end else if (pre_hit) begin
      pre_d = '0;
      div_d = div_hit ? '0 : div_q + DIV_W'(1);
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_d;
      div_q <= div_d;
    end
  end

  AST_DIV_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0 && div_q == '0)); // R10

endmodule

// File: rtl/twi_byte_ctrl.sv
module twi_byte_ctrl
  import twi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic          cmd_ack,
  input  logic [DW-1:0] tx_byte,
  input  logic          tick,
  input  logic          scl_in,
  input  logic          sda_in,
  output logic          scl_lo,
  output logic          sda_lo,
  output logic          busy,
  output logic          done,
  output logic [4:0]    code,
  output logic          rx_valid,
  output logic [DW-1:0] rx_byte
);

  localparam int             BCW  = $clog2(DW + 1);
  localparam logic [BCW-1:0] LAST = BCW'(DW);

  twi_st_e       state_q, state_d;
  logic [1:0]    qtr_q, qtr_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          ackdrv_q, ackdrv_d;
  logic          rxm_q, rxm_d;
  logic          rw_q, rw_d;
  logic          addr_q, addr_d;
  logic          own_q, own_d;
  logic          done_q, done_d;
  logic [4:0]    code_q, code_d;
  logic          scl_q, scl_d;
  logic          sda_q, sda_d;
  logic          ackin_q, ackin_d;
  logic          rxv_q, rxv_d;

  logic          accept, advance, ack_phase, tx_role, wire_bit;
  logic [4:0]    xfer_code;

  assign accept    = cmd_valid && (state_q == ST_IDLE);
  assign advance   = tick && (state_q != ST_IDLE) && !(qtr_q == 2'd2 && !scl_in);
  assign ack_phase = (bit_q == LAST);
  assign tx_role   = rxm_q ? ack_phase : !ack_phase;
  // level wanted on SDA for the current bit (1 = released)
  assign wire_bit  = ack_phase ? (rxm_q ? !ackdrv_q : 1'b1)
                               : (rxm_q ? 1'b1 : sh_q[DW-1]);

  always_comb begin
    if (rxm_q)       xfer_code = ackdrv_q ? C_RX_ACK : C_RX_NACK;
    else if (addr_q) xfer_code = rw_q ? (ackin_q ? C_AR_ACK : C_AR_NACK)
                                      : (ackin_q ? C_AW_ACK : C_AW_NACK);
    else             xfer_code = ackin_q ? C_TX_ACK : C_TX_NACK;
  end

  always_comb begin
    state_d  = state_q;
    qtr_d    = qtr_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    ackdrv_d = ackdrv_q;
    rxm_d    = rxm_q;
    rw_d     = rw_q;
    addr_d   = addr_q;
    own_d    = own_q;
    done_d   = done_q;
    code_d   = code_q;
    scl_d    = scl_q;
    sda_d    = sda_q;
    ackin_d  = ackin_q;
    rxv_d    = 1'b0;
    if (accept) begin
      done_d = 1'b0;
      qtr_d  = 2'd0;
      bit_d  = '0;
      unique case (twi_op_e'(cmd_op))
        OP_START: state_d = ST_START;
        OP_SEND: begin
          state_d = ST_XFER;
          rxm_d   = 1'b0;
          sh_d    = tx_byte;
          rw_d    = tx_byte[0];
        end
        OP_RECV: begin
          state_d  = ST_XFER;
          rxm_d    = 1'b1;
          ackdrv_d = cmd_ack;
        end
        default: state_d = ST_STOP;
      endcase
    end else if (advance) begin
      qtr_d = qtr_q + 2'd1;
      unique case (state_q)
        ST_START: begin
          unique case (qtr_q)
            2'd0: sda_d = 1'b0;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b1;
            default: begin
              scl_d   = 1'b1;
              state_d = ST_IDLE;
              done_d  = 1'b1;
              code_d  = own_q ? C_RSTART : C_START;
              own_d   = 1'b1;
              addr_d  = 1'b1;
            end
          endcase
        end
        ST_STOP: begin
          unique case (qtr_q)
            2'd0: sda_d = 1'b1;
            2'd1: scl_d = 1'b0;
            2'd2: sda_d = 1'b0;
            default: begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
              code_d  = C_IDLE;
              own_d   = 1'b0;
              addr_d  = 1'b0;
            end
          endcase
        end
        ST_XFER: begin
          unique case (qtr_q)
            2'd0: sda_d = !wire_bit;
            2'd1: scl_d = 1'b0;
            2'd2: begin
              if (tx_role && !sda_q && !sda_in) begin
                scl_d   = 1'b0;
                sda_d   = 1'b0;
                state_d = ST_IDLE;
                qtr_d   = 2'd0;
                done_d  = 1'b1;
                code_d  = C_ARB;
                own_d   = 1'b0;
                addr_d  = 1'b0;
              end else if (!ack_phase) begin
                sh_d = {sh_q[DW-2:0], sda_in};
              end else begin
                ackin_d = !sda_in;
              end
            end
            default: begin
              scl_d = 1'b1;
              if (ack_phase) begin
                state_d = ST_IDLE;
                done_d  = 1'b1;
                code_d  = xfer_code;
                rxv_d   = rxm_q;
                addr_d  = 1'b0;
              end else begin
                bit_d = bit_q + BCW'(1);
              end
            end
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      qtr_q    <= 2'd0;
      bit_q    <= '0;
      sh_q     <= '0;
      ackdrv_q <= 1'b0;
      rxm_q    <= 1'b0;
      rw_q     <= 1'b0;
      addr_q   <= 1'b0;
      own_q    <= 1'b0;
      done_q   <= 1'b0;
      code_q   <= C_IDLE;
      scl_q    <= 1'b0;
      sda_q    <= 1'b0;
      ackin_q  <= 1'b0;
      rxv_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      qtr_q    <= qtr_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
      ackdrv_q <= ackdrv_d;
      rxm_q    <= rxm_d;
      rw_q     <= rw_d;
      addr_q   <= addr_d;
      own_q    <= own_d;
      done_q   <= done_d;
      code_q   <= code_d;
      scl_q    <= scl_d;
      sda_q    <= sda_d;
      ackin_q  <= ackin_d;
      rxv_q    <= rxv_d;
    end
  end

  assign scl_lo   = scl_q;
  assign sda_lo   = sda_q;
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign code     = code_q;
  assign rx_valid = rxv_q;
  assign rx_byte  = sh_q;

  AST_SDA_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && $past(state_q == ST_XFER) && !scl_q && $past(!scl_q))
      |-> $stable(sda_q)); // R3
  AST_SCL_HELD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && own_q) |-> scl_q); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !cmd_valid) |=> done_q); // R7
  AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && code_q == C_ARB) |-> (!scl_q && !sda_q)); // R9

endmodule

// File: rtl/twi_step_master.sv
module twi_step_master
  import twi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             cmd_ack,
  input  logic             dat_wr,
  input  logic [DW-1:0]    dat_in,
  input  logic [1:0]       pre_sel,
  input  logic [DIV_W-1:0] rate_div,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             done,
  output logic             wr_coll,
  output logic [7:0]       status,
  output logic [DW-1:0]    data_out
);

  logic [1:0]    rst_sync_q;
  logic          rst_s_n;
  logic          tick, busy, rx_valid;
  logic [4:0]    code;
  logic [DW-1:0] rx_byte;
  logic [DW-1:0] data_q, data_d;
  logic          coll_q, coll_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  twi_rate_gen #(.DIV_W(DIV_W)) u_rate (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (busy),
    .pre_sel  (pre_sel),
    .rate_div (rate_div),
    .tick     (tick)
  );

  twi_byte_ctrl #(.DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_ack   (cmd_ack),
    .tx_byte   (data_q),
    .tick      (tick),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_lo    (scl_oe),
    .sda_lo    (sda_oe),
    .busy      (busy),
    .done      (done),
    .code      (code),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte)
  );

  always_comb begin
    data_d = data_q;
    coll_d = coll_q;
    if (rx_valid) begin
      data_d = rx_byte;
    end else if (dat_wr && done) begin
      data_d = dat_in;
      coll_d = 1'b0;
    end else if (dat_wr) begin
      coll_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      data_q <= '0;
      coll_q <= 1'b0;
    end else begin
      data_q <= data_d;
      coll_q <= coll_d;
    end
  end

  assign wr_coll  = coll_q;
  assign data_out = data_q;
  assign status   = {code, 1'b0, pre_sel};

  AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dat_wr && !done) |=> wr_coll); // R8
  AST_DATA_KEEP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (dat_wr && !done) |=> $stable(data_out)); // R8

endmodule

// File: tb/tb_twi_step_master.sv
module tb_twi_step_master;

  localparam int DW = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_ack, dat_wr;
  logic [1:0] cmd_op;
  logic [7:0] dat_in;
  logic [1:0] pre_sel;
  logic [7:0] rate_div;
  logic       scl_in, sda_in, scl_oe, sda_oe, done, wr_coll;
  logic [7:0] status, data_out;

  // bus partner controls
  int         sl_mode;    // 0 idle, 1 listen (answers ack bit), 2 talk (drives byte)
  logic       sl_ack;
  logic [7:0] sl_byte;
  logic       stretch;
  logic       slave_lo;

  int   n_chk = 0, n_err = 0;
  int   cyc = 0, last_rise = 0, rise_gap = 0, rises = 0;
  int   start_cnt = 0, stop_cnt = 0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  logic [8:0] cap = '0;

  always #4 clk = ~clk;

  assign scl_in = !scl_oe && !stretch;
  assign sda_in = !sda_oe && !slave_lo;

  twi_step_master dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_ack(cmd_ack), .dat_wr(dat_wr), .dat_in(dat_in), .pre_sel(pre_sel),
    .rate_div(rate_div), .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .done(done), .wr_coll(wr_coll), .status(status),
    .data_out(data_out)
  );

  function automatic logic slv_bit(int i);
    if (sl_mode == 1) return (i == 8) ? sl_ack : 1'b0;
    if (sl_mode == 2) return (i < 8) ? !sl_byte[7-i] : 1'b0;
    return 1'b0;
  endfunction

  // bus monitor and slave model, sampling at the falling clock edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (scl_in && !scl_p) begin
      cap = {cap[7:0], sda_in};
      if (last_rise != 0) rise_gap = cyc - last_rise;
      last_rise = cyc;
      rises = rises + 1;
    end
    if (scl_p && scl_in && sda_p && !sda_in) start_cnt = start_cnt + 1;
    if (scl_p && scl_in && !sda_p && sda_in) stop_cnt = stop_cnt + 1;
    if (cmd_valid) begin
      rises = 0;
      slave_lo = slv_bit(0);
    end else if (scl_p && !scl_in) begin
      slave_lo = slv_bit(rises);
    end
    scl_p = scl_in;
    sda_p = sda_in;
  end

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_done(string req);
    int k;
    k = 0;
    while (!done && k < 5000) begin
      step();
      k++;
    end
    check({req, " step finished"}, done, 1);
    step();
    step();
  endtask

  task automatic issue(int op, logic ack);
    step();
    cmd_valid = 1'b1;
    cmd_op    = 2'(op);
    cmd_ack   = ack;
    step();
    cmd_valid = 1'b0;
  endtask

  task automatic do_cmd(string req, int op, logic ack);
    issue(op, ack);
    wait_done(req);
  endtask

  task automatic wr_data(logic [7:0] v);
    step();
    dat_wr = 1'b1;
    dat_in = v;
    step();
    dat_wr = 1'b0;
    step();
  endtask

  function automatic int st(int c);
    return (c << 3) | int'(pre_sel);
  endfunction

  task automatic t_reset();
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 done", done, 0);
    check("R1 wr_coll", wr_coll, 0);
    check("R1 data_out", data_out, 0);
    check("R1 R12 status idle", status, 8'hF8);
  endtask

  task automatic t_coll_idle();
    wr_data(8'h77);
    check("R8 write without done sets wr_coll", wr_coll, 1);
    check("R8 rejected write keeps data", data_out, 8'h00);
  endtask

  task automatic t_start(int exp_code, string req);
    int s0;
    s0 = start_cnt;
    do_cmd(req, 0, 1'b0);
    check({req, " status"}, status, st(exp_code));
    check({req, " start edge on bus"}, start_cnt - s0, 1);
    check({req, " SCL held low"}, scl_oe, 1);
    check({req, " SDA low"}, sda_oe, 1);
  endtask

  task automatic t_send(logic [7:0] b, logic ack, int exp_code, string req);
    int s0, p0;
    wr_data(b);
    check({req, " R8 write accepted"}, wr_coll, 0);
    check({req, " R8 data register"}, data_out, b);
    sl_mode = 1;
    sl_ack  = ack;
    s0 = start_cnt;
    p0 = stop_cnt;
    do_cmd(req, 1, 1'b0);
    check({req, " R3 bits MSB first"}, cap[8:1], b);
    check({req, " R3 ack level"}, cap[0], ack ? 0 : 1);
    check({req, " R3 no start/stop inside byte"}, (start_cnt - s0) + (stop_cnt - p0), 0);
    check({req, " status"}, status, st(exp_code));
    check({req, " R7 SCL held after done"}, scl_oe, 1);
    sl_mode = 0;
  endtask

  task automatic t_recv(logic [7:0] b, logic ack, int exp_code, string req);
    sl_mode = 2;
    sl_byte = b;
    do_cmd(req, 2, ack);
    check({req, " received byte"}, data_out, b);
    check({req, " master answer bit"}, cap[0], ack ? 0 : 1);
    check({req, " status"}, status, st(exp_code));
    sl_mode = 0;
  endtask

  task automatic t_busy_ignore();
    int p0;
    wr_data(8'h3C);
    sl_mode = 1;
    sl_ack  = 1'b1;
    p0 = stop_cnt;
    issue(1, 1'b0);
    step();
    issue(3, 1'b0);    // arrives while the byte is still in flight
    wait_done("R7");
    check("R7 busy command ignored: status", status, st(5'h05));
    check("R7 busy command ignored: SCL still held", scl_oe, 1);
    check("R7 busy command ignored: no stop", stop_cnt - p0, 0);
    sl_mode = 0;
  endtask

  task automatic t_stop_stretch();
    int p0;
    p0 = stop_cnt;
    stretch = 1'b1;
    issue(3, 1'b0);
    repeat (40) step();
    check("R11 waits while SCL held low: done", done, 0);
    check("R11 waits while SCL held low: SDA still low", sda_oe, 1);
    stretch = 1'b0;
    wait_done("R6");
    check("R6 stop edge on bus", stop_cnt - p0, 1);
    check("R6 lines released", {scl_oe, sda_oe}, 0);
    check("R6 status idle", status, st(5'h1F));
  endtask

  task automatic t_rate();
    pre_sel  = 2'b01;
    rate_div = 8'd2;
    t_start(5'h01, "R10 R2 start");
    t_send(8'h54, 1'b0, 5'h04, "R10 R4 addr+W nack");
    check("R10 SCL period 4*4*3", rise_gap, 48);
    check("R12 status prescaler field", status[2:0], 3'b001);
    do_cmd("R6 stop", 3, 1'b0);
    pre_sel  = 2'b00;
    rate_div = 8'd1;
  endtask

  task automatic t_arb();
    t_start(5'h01, "R2 start before contest");
    wr_data(8'hFF);
    sl_mode = 2;
    sl_byte = 8'hBF;   // other master pulls SDA low in bit 6
    do_cmd("R9", 1, 1'b0);
    check("R9 status arbitration lost", status, st(5'h07));
    check("R9 lines released", {scl_oe, sda_oe}, 0);
    sl_mode = 0;
    t_start(5'h01, "R9 fresh start after loss");
    do_cmd("R6 stop", 3, 1'b0);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_ack = 1'b0;
    dat_wr = 1'b0; dat_in = 8'h00; pre_sel = 2'b00; rate_div = 8'd1;
    sl_mode = 0; sl_ack = 1'b0; sl_byte = 8'h00; stretch = 1'b0; slave_lo = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    t_reset();
    t_coll_idle();
    t_start(5'h01, "R2 start");
    t_send(8'h9A, 1'b1, 5'h03, "R4 addr+W ack");
    t_send(8'hF0, 1'b0, 5'h06, "R4 data nack");
    t_busy_ignore();
    t_start(5'h02, "R2 repeated start");
    t_send(8'h9B, 1'b1, 5'h08, "R4 addr+R ack");
    t_recv(8'h5C, 1'b1, 5'h0A, "R5 recv ack");
    t_recv(8'hA3, 1'b0, 5'h0B, "R5 recv nack");
    t_stop_stretch();
    t_rate();
    t_arb();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule